// File: doc/BRIEF.md
# Banked Display RAM Write Address Generator

This block computes write addresses for a display memory that is organised as 102 columns by 9 row banks of 8 bits each. A command decoder upstream feeds it single-cycle strobes: function set, set column, set bank and data write. The block holds a column pointer and a bank pointer. It turns each data write into a registered linear RAM address, a write enable and a per-bit lane mask. After each write it advances the pointers automatically.

A function set loads three mode flags: the stepping direction, the command page and power down. In horizontal mode a write advances the column first. In vertical mode it advances the bank first. The pointers wrap at their limits, and no out-of-range address is ever produced. Pointer load commands take effect only while the command page flag is 0. The last bank stores only the least significant bit of each byte, so its writes enable a single lane. Power down leaves memory writes and pointer stepping untouched.

Top module: `disp_addr_gen`

## Requirements
- R1: After reset both pointers are 0, the stepping, page and power-down outputs read 0, 0 and 1, and `ram_we_o` and `lane_mask_o` are 0.
- R2: A `wr_i` pulse produces exactly one cycle of `ram_we_o`=1 on the next clock, with `ram_addr_o` = bank*102 + column taken from the pointers as they were before the write.
- R3: With stepping flag 0 (horizontal), each write increments the column. Column 101 wraps to 0 and increments the bank. Bank 8 wraps to 0.
- R4: With stepping flag 1 (vertical), each write increments the bank. Bank 8 wraps to 0 and increments the column. Column 101 wraps to 0.
- R5: `set_x_i` loads the column pointer from `x_val_i` when the page flag is 0. Values above 101 load 0.
- R6: `set_y_i` loads the bank pointer from `y_val_i` when the page flag is 0. Values above 8 load 0.
- R7: While the page flag is 1, `set_x_i` and `set_y_i` leave both pointers unchanged.
- R8: A function set is accepted in either page. It loads the stepping flag from `func_vert_i`, the page flag from `func_page_i` and power down from `func_pd_i`. Writes are accepted in either page.
- R9: `lane_mask_o` is 8'h01 for a write to bank 8, 8'hFF for a write to banks 0 to 7, and 0 in cycles without a write.
- R10: With power down set to 1, writes still produce RAM writes and step the pointers.
- R11: `ram_addr_o` is below 918 whenever `ram_we_o` is 1, and the pointers never leave 0..101 and 0..8.
- R12: If an accepted set command coincides with a write, the write uses the old pointers. The set value then replaces the stepped value on that axis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| func_set_i | input | 1 | Function set strobe |
| func_vert_i | input | 1 | Stepping flag value (1 = vertical) |
| func_page_i | input | 1 | Command page value |
| func_pd_i | input | 1 | Power-down value |
| set_x_i | input | 1 | Set column strobe |
| x_val_i | input | 7 | Column value |
| set_y_i | input | 1 | Set bank strobe |
| y_val_i | input | 4 | Bank value |
| wr_i | input | 1 | Data write strobe |
| ram_addr_o | output | 10 | Registered linear RAM address |
| ram_we_o | output | 1 | Registered RAM write enable |
| lane_mask_o | output | 8 | Registered bit-lane write mask |
| vert_o | output | 1 | Current stepping flag |
| page_o | output | 1 | Current command page flag |
| pd_o | output | 1 | Current power-down flag |

## Verification
The checker watches several properties on every cycle. It confirms that the pointers and the emitted address stay in range and that the write enable follows each write strobe by exactly one cycle. It checks that the lane mask matches the bank implied by the address. It also confirms that gated set commands leave the pointers alone, and that the off-axis pointer holds during a non-wrapping step. The exact pointer sequences are shown only by the directed bench scenarios. These cover wrap carries in both modes, clamping of oversized set values, same-cycle set-with-write priority, and writes during power down.

// File: rtl/disp_addr_pkg.sv
package disp_addr_pkg;
  typedef struct packed {
    logic vert;
    logic page;
    logic pd;
  } disp_mode_t;

  localparam disp_mode_t MODE_RST = '{vert: 1'b0, page: 1'b0, pd: 1'b1};
endpackage

// File: rtl/disp_mode_reg.sv
module disp_mode_reg
  import disp_addr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       func_set_i,
  input  disp_mode_t mode_d_i,
  output disp_mode_t mode_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mode_q_o <= MODE_RST;
    else if (func_set_i) mode_q_o <= mode_d_i;
  end
endmodule

// File: rtl/disp_ptr_step.sv
module disp_ptr_step #(
  parameter int NUM_COLS  = 102,
  parameter int NUM_BANKS = 9,
  parameter int XW        = $clog2(NUM_COLS),
  parameter int YW        = $clog2(NUM_BANKS)
) (
  input  logic          vert_i,
  input  logic [XW-1:0] x_i,
  input  logic [YW-1:0] y_i,
  output logic [XW-1:0] x_nx_o,
  output logic [YW-1:0] y_nx_o
);
  localparam logic [XW-1:0] LAST_X = XW'(NUM_COLS - 1);
  localparam logic [YW-1:0] LAST_Y = YW'(NUM_BANKS - 1);

  logic x_end, y_end;
  logic [XW-1:0] x_inc;
  logic [YW-1:0] y_inc;

  assign x_end = (x_i == LAST_X);
  assign y_end = (y_i == LAST_Y);
  assign x_inc = x_end ? '0 : x_i + XW'(1);
  assign y_inc = y_end ? '0 : y_i + YW'(1);

  // fast axis always steps; slow axis steps on fast-axis wrap
  always_comb begin
    if (vert_i) begin
      y_nx_o = y_inc;
      x_nx_o = y_end ? x_inc : x_i;
    end else begin
      x_nx_o = x_inc;
      y_nx_o = x_end ? y_inc : y_i;
    end
  end
endmodule

// File: rtl/disp_ptr_reg.sv
module disp_ptr_reg #(
  parameter int NUM_COLS  = 102,
  parameter int NUM_BANKS = 9,
  parameter int XW        = $clog2(NUM_COLS),
  parameter int YW        = $clog2(NUM_BANKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          ld_x_i,
  input  logic [XW-1:0] x_val_i,
  input  logic          ld_y_i,
  input  logic [YW-1:0] y_val_i,
  input  logic [XW-1:0] x_nx_i,
  input  logic [YW-1:0] y_nx_i,
  output logic [XW-1:0] x_q_o,
  output logic [YW-1:0] y_q_o
);
  localparam logic [XW-1:0] LAST_X = XW'(NUM_COLS - 1);
  localparam logic [YW-1:0] LAST_Y = YW'(NUM_BANKS - 1);

  logic [XW-1:0] x_ld;
  logic [YW-1:0] y_ld;

  // out-of-range loads fold to the wrap value
  assign x_ld = (x_val_i > LAST_X) ? '0 : x_val_i;
  assign y_ld = (y_val_i > LAST_Y) ? '0 : y_val_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q_o <= '0;
      y_q_o <= '0;
    end else begin
      if (ld_x_i)    x_q_o <= x_ld;
      else if (wr_i) x_q_o <= x_nx_i;
      if (ld_y_i)    y_q_o <= y_ld;
      else if (wr_i) y_q_o <= y_nx_i;
    end
  end
endmodule

// File: rtl/disp_wr_out.sv
module disp_wr_out #(
  parameter int NUM_COLS  = 102,
  parameter int NUM_BANKS = 9,
  parameter int DATA_W    = 8,
  parameter int PART_BITS = 1,
  parameter int XW        = $clog2(NUM_COLS),
  parameter int YW        = $clog2(NUM_BANKS),
  parameter int AW        = $clog2(NUM_COLS * NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [XW-1:0]     x_i,
  input  logic [YW-1:0]     y_i,
  output logic [AW-1:0]     addr_o,
  output logic              we_o,
  output logic [DATA_W-1:0] mask_o
);
  localparam logic [YW-1:0] LAST_Y = YW'(NUM_BANKS - 1);

  logic [AW-1:0]     addr_d;
  logic [DATA_W-1:0] mask_d;
  logic              part_bank;

  assign part_bank = (y_i == LAST_Y);
  assign addr_d    = AW'(y_i) * AW'(NUM_COLS) + AW'(x_i);

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    if (i < PART_BITS) begin : g_kept
      assign mask_d[i] = 1'b1;
    end else begin : g_full
      assign mask_d[i] = ~part_bank;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      we_o   <= 1'b0;
      mask_o <= '0;
    end else begin
      we_o   <= wr_i;
      mask_o <= wr_i ? mask_d : '0;
      if (wr_i) addr_o <= addr_d;
    end
  end
endmodule

// File: rtl/disp_addr_gen.sv
module disp_addr_gen
  import disp_addr_pkg::*;
#(
  parameter int NUM_COLS  = 102,
  parameter int NUM_BANKS = 9,
  parameter int DATA_W    = 8,
  parameter int PART_BITS = 1,
  localparam int XW       = $clog2(NUM_COLS),
  localparam int YW       = $clog2(NUM_BANKS),
  localparam int AW       = $clog2(NUM_COLS * NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              func_set_i,
  input  logic              func_vert_i,
  input  logic              func_page_i,
  input  logic              func_pd_i,
  input  logic              set_x_i,
  input  logic [XW-1:0]     x_val_i,
  input  logic              set_y_i,
  input  logic [YW-1:0]     y_val_i,
  input  logic              wr_i,
  output logic [AW-1:0]     ram_addr_o,
  output logic              ram_we_o,
  output logic [DATA_W-1:0] lane_mask_o,
  output logic              vert_o,
  output logic              page_o,
  output logic              pd_o
);
  disp_mode_t    mode_q, mode_d;
  logic [XW-1:0] x_q, x_nx;
  logic [YW-1:0] y_q, y_nx;
  logic          ld_x, ld_y;

  assign mode_d = '{vert: func_vert_i, page: func_page_i, pd: func_pd_i};
  assign ld_x   = set_x_i & ~mode_q.page;
  assign ld_y   = set_y_i & ~mode_q.page;

  disp_mode_reg u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .func_set_i (func_set_i),
    .mode_d_i   (mode_d),
    .mode_q_o   (mode_q)
  );

  disp_ptr_step #(.NUM_COLS(NUM_COLS), .NUM_BANKS(NUM_BANKS), .XW(XW), .YW(YW)) u_step (
    .vert_i (mode_q.vert),
    .x_i    (x_q),
    .y_i    (y_q),
    .x_nx_o (x_nx),
    .y_nx_o (y_nx)
  );

  disp_ptr_reg #(.NUM_COLS(NUM_COLS), .NUM_BANKS(NUM_BANKS), .XW(XW), .YW(YW)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .ld_x_i  (ld_x),
    .x_val_i (x_val_i),
    .ld_y_i  (ld_y),
    .y_val_i (y_val_i),
    .x_nx_i  (x_nx),
    .y_nx_i  (y_nx),
    .x_q_o   (x_q),
    .y_q_o   (y_q)
  );

  disp_wr_out #(
    .NUM_COLS(NUM_COLS), .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W),
    .PART_BITS(PART_BITS), .XW(XW), .YW(YW), .AW(AW)
  ) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .x_i    (x_q),
    .y_i    (y_q),
    .addr_o (ram_addr_o),
    .we_o   (ram_we_o),
    .mask_o (lane_mask_o)
  );

  assign vert_o = mode_q.vert;
  assign page_o = mode_q.page;
  assign pd_o   = mode_q.pd;
endmodule

// File: rtl/disp_addr_gen_chk.sv
module disp_addr_gen_chk #(
  parameter int NUM_COLS  = 102,
  parameter int NUM_BANKS = 9,
  parameter int DATA_W    = 8,
  parameter int PART_BITS = 1,
  parameter int XW        = $clog2(NUM_COLS),
  parameter int YW        = $clog2(NUM_BANKS),
  parameter int AW        = $clog2(NUM_COLS * NUM_BANKS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              set_x_i,
  input logic              set_y_i,
  input logic              wr_i,
  input logic              func_set_i,
  input logic [AW-1:0]     ram_addr_o,
  input logic              ram_we_o,
  input logic [DATA_W-1:0] lane_mask_o,
  input logic              vert_o,
  input logic              page_o,
  input logic [XW-1:0]     x_q,
  input logic [YW-1:0]     y_q
);
  localparam int              LIMIT     = NUM_COLS * NUM_BANKS;
  localparam int              PART_BASE = (NUM_BANKS - 1) * NUM_COLS;
  localparam logic [XW-1:0]   LAST_X    = XW'(NUM_COLS - 1);
  localparam logic [YW-1:0]   LAST_Y    = YW'(NUM_BANKS - 1);
  localparam logic [DATA_W-1:0] PART_MASK = DATA_W'((1 << PART_BITS) - 1);

  AST_X_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_q <= LAST_X); // R11
  AST_Y_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_q <= LAST_Y); // R11
  AST_ADDR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (int'(ram_addr_o) < LIMIT)); // R11
  AST_WE_FOLLOWS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ram_we_o); // R2
  AST_WE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> !ram_we_o); // R2
  AST_MASK_PART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && int'(ram_addr_o) >= PART_BASE) |-> lane_mask_o == PART_MASK); // R9
  AST_MASK_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && int'(ram_addr_o) < PART_BASE) |-> (&lane_mask_o)); // R9
  AST_MASK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_o |-> lane_mask_o == '0); // R9
  AST_GATED_X_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_o && set_x_i && !wr_i) |=> $stable(x_q)); // R7
  AST_GATED_Y_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_o && set_y_i && !wr_i) |=> $stable(y_q)); // R7
  AST_H_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !vert_o && !set_y_i && x_q != LAST_X) |=> $stable(y_q)); // R3
  AST_V_COL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && vert_o && !set_x_i && y_q != LAST_Y) |=> $stable(x_q)); // R4
  AST_FUNC_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !func_set_i |=> $stable(page_o)); // R8
endmodule

bind disp_addr_gen disp_addr_gen_chk #(
  .NUM_COLS(NUM_COLS), .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .PART_BITS(PART_BITS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .set_x_i     (set_x_i),
  .set_y_i     (set_y_i),
  .wr_i        (wr_i),
  .func_set_i  (func_set_i),
  .ram_addr_o  (ram_addr_o),
  .ram_we_o    (ram_we_o),
  .lane_mask_o (lane_mask_o),
  .vert_o      (vert_o),
  .page_o      (page_o),
  .x_q         (x_q),
  .y_q         (y_q)
);

// File: tb/sim_disp_addr_gen.sv
`timescale 1ns/1ps
module sim_disp_addr_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic func_set = 0, func_vert = 0, func_page = 0, func_pd = 0;
  logic set_x = 0, set_y = 0, wr = 0;
  logic [6:0] x_val = '0;
  logic [3:0] y_val = '0;
  logic [9:0] ram_addr;
  logic       ram_we;
  logic [7:0] lane_mask;
  logic       vert, page, pd;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model of the pointers and mode
  int ex = 0, ey = 0;
  bit ev = 0, eh = 0;

  always #5 clk = ~clk;

  disp_addr_gen u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .func_set_i(func_set), .func_vert_i(func_vert), .func_page_i(func_page), .func_pd_i(func_pd),
    .set_x_i(set_x), .x_val_i(x_val), .set_y_i(set_y), .y_val_i(y_val), .wr_i(wr),
    .ram_addr_o(ram_addr), .ram_we_o(ram_we), .lane_mask_o(lane_mask),
    .vert_o(vert), .page_o(page), .pd_o(pd)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step();
    if (!ev) begin
      if (ex == 101) begin ex = 0; ey = (ey == 8) ? 0 : ey + 1; end
      else ex++;
    end else begin
      if (ey == 8) begin ey = 0; ex = (ex == 101) ? 0 : ex + 1; end
      else ey++;
    end
  endtask

  task automatic cmd_func(bit v, bit h, bit p);
    @(negedge clk);
    func_set = 1; func_vert = v; func_page = h; func_pd = p;
    @(negedge clk);
    func_set = 0;
    ev = v; eh = h;
    check("R8 vert", vert, v);
    check("R8 page", page, h);
    check("R8 pd", pd, p);
  endtask

  task automatic cmd_x(int v);
    @(negedge clk);
    set_x = 1; x_val = 7'(v);
    @(negedge clk);
    set_x = 0;
    if (!eh) ex = (v > 101) ? 0 : v;
  endtask

  task automatic cmd_y(int v);
    @(negedge clk);
    set_y = 1; y_val = 4'(v);
    @(negedge clk);
    set_y = 0;
    if (!eh) ey = (v > 8) ? 0 : v;
  endtask

  task automatic do_write(string req);
    int ea, em;
    ea = ey * 102 + ex;
    em = (ey == 8) ? 8'h01 : 8'hFF;
    @(negedge clk);
    wr = 1;
    @(negedge clk);
    wr = 0;
    check({req, " R2 we"}, ram_we, 1);
    check({req, " R2 addr"}, ram_addr, ea);
    check({req, " R9 mask"}, lane_mask, em);
    model_step();
  endtask

  task automatic t_reset();
    check("R1 we", ram_we, 0);
    check("R1 mask", lane_mask, 0);
    check("R1 vert", vert, 0);
    check("R1 page", page, 0);
    check("R1 pd", pd, 1);
    do_write("R1 ptr");
    @(negedge clk);
    check("R2 we single", ram_we, 0);
    check("R9 mask idle", lane_mask, 0);
  endtask

  task automatic t_horizontal();
    cmd_func(0, 0, 0);
    cmd_x(0); cmd_y(0);
    for (int i = 0; i < 3; i++) do_write("R3 run");
    cmd_x(100); cmd_y(3);
    for (int i = 0; i < 3; i++) do_write("R3 col wrap");
    cmd_x(101); cmd_y(8);
    do_write("R3 last");
    do_write("R3 full wrap");
    check("R3 wrap addr", ram_addr, 0);
  endtask

  task automatic t_vertical();
    cmd_func(1, 0, 0);
    cmd_x(3); cmd_y(7);
    for (int i = 0; i < 3; i++) do_write("R4 run");
    check("R4 carry addr", ram_addr, 4);
    cmd_x(101); cmd_y(8);
    do_write("R4 last");
    do_write("R4 full wrap");
    check("R4 wrap addr", ram_addr, 0);
  endtask

  task automatic t_clamp();
    cmd_func(0, 0, 0);
    cmd_x(50); cmd_y(2);
    cmd_x(127);
    do_write("R5 clamp");
    cmd_x(102);
    do_write("R5 clamp edge");
    cmd_x(40); cmd_y(15);
    do_write("R6 clamp");
    cmd_y(9);
    do_write("R6 clamp edge");
    cmd_y(8); cmd_x(7);
    do_write("R5 R6 load");
  endtask

  task automatic t_page();
    cmd_func(0, 0, 0);
    cmd_x(10); cmd_y(1);
    cmd_func(0, 1, 0);
    cmd_x(60); cmd_y(5);
    do_write("R7 ignored");
    check("R7 addr", ram_addr, 1 * 102 + 10);
    do_write("R8 write page1");
    cmd_func(1, 1, 0);
    do_write("R8 func page1");
    cmd_func(0, 0, 0);
    cmd_x(60);
    do_write("R7 reenabled");
  endtask

  task automatic t_pd();
    cmd_func(0, 0, 1);
    cmd_x(101); cmd_y(4);
    do_write("R10 pd");
    do_write("R10 pd step");
    check("R10 addr", ram_addr, 5 * 102);
    cmd_func(0, 0, 0);
  endtask

  task automatic t_same_cycle();
    cmd_func(0, 0, 0);
    cmd_x(5); cmd_y(2);
    @(negedge clk);
    wr = 1; set_x = 1; x_val = 7'd20;
    @(negedge clk);
    wr = 0; set_x = 0;
    check("R12 old addr", ram_addr, 2 * 102 + 5);
    model_step(); ex = 20;
    do_write("R12 override");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_horizontal();
    t_vertical();
    t_clamp();
    t_page();
    t_pd();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule